// File: doc/BRIEF.md
# CAN Error Flag and Interrupt Unit

This unit gathers error events reported by a CAN protocol engine and turns them into sticky flags that software can read and clear. Eight event pulses (bus lock, overload frame, receive overrun, bus-off recovery, bus-off entry, error passive, error warning and bus error) each set one bit of an error-flag byte. Each bit sets only when the matching bit of an enable byte is 1. When a bus error arrives, a separate cause byte records which protocol faults caused it. The byte either accumulates causes across errors or holds only the causes of the most recent error, depending on its own mode bit.

Any set flag raises a pending bit in a top-level status byte. An enable byte at the top level gates that bit onto the single interrupt line. Software clears flags and causes by writing a byte in which the bits to clear are 0. The transmit and receive error counts come from the engine and can be read at two addresses of their own. Reads are combinational and writes take effect at the clock edge.

Top module: `can_err_flags`

## Requirements
- R1: After reset, the flag, enable, cause, status and top-enable bytes read 0 and `irq` is low.
- R2: Event bit i of `ev_pulse` sets flag bit i only if enable bit i is 1. The bit order from 7 down to 0 is bus lock, overload, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error. The flag byte is read at address 0.
- R3: A write to address 0 clears each flag bit written as 0 and leaves each bit written as 1 unchanged.
- R4: If an enabled event and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R5: Cause byte bit 7 is the mode bit, read at address 2. When the mode bit is 1, a bus-error pulse ORs `cause_in` into bits 6:0. The cause order from 6 down to 0 is ACK delimiter, dominant bit, recessive bit, CRC, ACK, form, stuff.
- R6: When the mode bit is 0, a bus-error pulse replaces bits 6:0 with `cause_in`.
- R7: A write to address 2 stores bit 7 as the mode. It clears each cause bit written as 0 and keeps each cause bit written as 1.
- R8: The status byte at address 3 has bit 5 set exactly when any flag is set; its other bits read 0. `irq` is status bit 5 AND bit 5 of the top-enable byte, which is written and read at address 4.
- R9: Address 5 reads `tx_err_cnt`, address 6 reads `rx_err_cnt`, and address 7 reads 0.
- R10: The enable byte is written and read at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ev_pulse | input | 8 | Single-cycle error event pulses |
| cause_in | input | 7 | Bus-error causes, valid with `ev_pulse[0]` |
| tx_err_cnt | input | 8 | Transmit error count from the engine |
| rx_err_cnt | input | 8 | Receive error count from the engine |
| irq | output | 1 | Error interrupt |

## Verification
Two functions can fall in the same cycle: a software clear of the flag byte and a hardware event that sets one of its bits. The bench drives a write of 0x00 to the flag byte in the same cycle as an enabled error-warning pulse. It then expects the warning bit alone to remain set, while a flag that was set before that cycle is cleared. A similar collision is checked on the cause byte, where a clearing write meets a bus-error capture.

// File: rtl/can_err_flags.sv
module can_err_flags #(
  parameter int AW       = 3,
  parameter int DW       = 8,
  parameter int NCAUSE   = 7,
  parameter int STAT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     ev_pulse,
  input  logic [NCAUSE-1:0] cause_in,
  input  logic [DW-1:0]     tx_err_cnt,
  input  logic [DW-1:0]     rx_err_cnt,
  output logic              irq
);
  localparam logic [AW-1:0] A_FLAG = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_CODE = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_TEN  = AW'(4);
  localparam logic [AW-1:0] A_TXC  = AW'(5);
  localparam logic [AW-1:0] A_RXC  = AW'(6);

  logic [DW-1:0]     flag_q, en_q;
  logic [NCAUSE-1:0] cause_q, cause_keep;
  logic              mode_q, topen_q, pending;
  logic              wr_flag, wr_code;

  assign wr_flag    = wr_en && (addr == A_FLAG);
  assign wr_code    = wr_en && (addr == A_CODE);
  assign cause_keep = cause_q & ~({NCAUSE{wr_code}} & ~wdata[NCAUSE-1:0]);
  assign pending    = |flag_q;
  assign irq        = pending && topen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= '0;
      en_q    <= '0;
      cause_q <= '0;
      mode_q  <= 1'b0;
      topen_q <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~({DW{wr_flag}} & ~wdata)) | (ev_pulse & en_q);
      if (wr_en && addr == A_EN) en_q <= wdata;
      if (wr_en && addr == A_TEN) topen_q <= wdata[STAT_BIT];
      if (wr_code) mode_q <= wdata[DW-1];
      if (ev_pulse[0]) cause_q <= mode_q ? (cause_keep | cause_in) : cause_in;
      else             cause_q <= cause_keep;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_FLAG: rdata = flag_q;
      A_EN:   rdata = en_q;
      A_CODE: rdata = {mode_q, cause_q};
      A_STAT: rdata[STAT_BIT] = pending;
      A_TEN:  rdata[STAT_BIT] = topen_q;
      A_TXC:  rdata = tx_err_cnt;
      A_RXC:  rdata = rx_err_cnt;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/can_err_flags_chk.sv
module can_err_flags_chk #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int NCAUSE = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     ev_pulse,
  input logic [NCAUSE-1:0] cause_in,
  input logic [DW-1:0]     flag_q,
  input logic [DW-1:0]     en_q,
  input logic [NCAUSE-1:0] cause_q,
  input logic              mode_q,
  input logic              irq
);
  // R2: a flag can only rise through an enabled event
  a_r2_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~$past(flag_q) & ~$past(ev_pulse & en_q)) == '0);

  // R3: bits written as 1 survive a write to the flag byte
  a_r3_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0)) |=> ((flag_q & $past(flag_q & wdata)) == $past(flag_q & wdata)));

  // R4: an enabled event always leaves its flag set, whatever the write
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev_pulse & en_q) & ~flag_q) == '0));

  // R6: latest-only mode holds exactly the newest causes
  a_r6_latest_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse[0] && !mode_q) |=> (cause_q == $past(cause_in)));

  // R8: the interrupt line needs a pending flag
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q != '0));
endmodule

bind can_err_flags can_err_flags_chk #(.AW(AW), .DW(DW), .NCAUSE(NCAUSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ev_pulse(ev_pulse), .cause_in(cause_in), .flag_q(flag_q), .en_q(en_q),
  .cause_q(cause_q), .mode_q(mode_q), .irq(irq)
);

// File: tb/can_err_flags_tb.sv
module can_err_flags_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] ev_pulse = '0;
  logic [6:0] cause_in = '0;
  logic [7:0] tx_err_cnt = '0;
  logic [7:0] rx_err_cnt = '0;
  logic       irq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_err_flags u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_pulse(ev_pulse), .cause_in(cause_in),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] ev, input logic [6:0] c);
    @(negedge clk);
    ev_pulse = ev; cause_in = c;
    @(negedge clk);
    ev_pulse = '0; cause_in = '0;
  endtask

  task automatic t_reset;
    rd(3'd0, "R1 flags", 8'h00);
    rd(3'd1, "R1 enable", 8'h00);
    rd(3'd2, "R1 cause", 8'h00);
    rd(3'd3, "R1 status", 8'h00);
    rd(3'd4, "R1 top enable", 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_enable_gate;
    pulse(8'h80, '0);
    rd(3'd0, "R2 masked event", 8'h00);
    wr(3'd1, 8'hFF);
    rd(3'd1, "R10 enable readback", 8'hFF);
    pulse(8'h81, 7'h00);
    rd(3'd0, "R2 enabled events", 8'h81);
    rd(3'd3, "R8 status pending", 8'h20);
    chk("R8 irq gated off", {7'd0, irq}, 8'h00);
    wr(3'd4, 8'h20);
    rd(3'd4, "R8 top enable readback", 8'h20);
    chk("R8 irq on", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_clear;
    wr(3'd0, 8'hFE);
    rd(3'd0, "R3 clear bit0", 8'h80);
    wr(3'd0, 8'hFF);
    rd(3'd0, "R3 ones keep", 8'h80);
    wr(3'd0, 8'h7F);
    rd(3'd0, "R3 clear bit7", 8'h00);
    rd(3'd3, "R8 status idle", 8'h00);
    chk("R8 irq off", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_collision;
    pulse(8'h04, '0);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wdata = 8'h00; ev_pulse = 8'h02;
    @(negedge clk);
    wr_en = 1'b0; ev_pulse = '0;
    rd(3'd0, "R4 event beats clear", 8'h02);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_accumulate;
    wr(3'd2, 8'h80);
    pulse(8'h01, 7'h01);
    rd(3'd2, "R5 first cause", 8'h81);
    pulse(8'h01, 7'h08);
    rd(3'd2, "R5 accumulated", 8'h89);
    pulse(8'h01, 7'h76);
    rd(3'd2, "R5 all causes", 8'hFF);
    wr(3'd2, 8'hFD);
    rd(3'd2, "R7 clear one cause", 8'hFD);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd2; wdata = 8'h80; ev_pulse = 8'h01; cause_in = 7'h10;
    @(negedge clk);
    wr_en = 1'b0; ev_pulse = '0; cause_in = '0;
    rd(3'd2, "R7 capture beats clear", 8'h90);
  endtask

  task automatic t_latest;
    wr(3'd2, 8'h00);
    rd(3'd2, "R7 mode off and clear", 8'h00);
    pulse(8'h01, 7'h05);
    rd(3'd2, "R6 latest first", 8'h05);
    pulse(8'h01, 7'h40);
    rd(3'd2, "R6 latest replaces", 8'h40);
    pulse(8'h02, 7'h3F);
    rd(3'd2, "R6 non-bus-error ignored", 8'h40);
  endtask

  task automatic t_counts;
    tx_err_cnt = 8'h5A; rx_err_cnt = 8'hA5;
    rd(3'd5, "R9 tx count", 8'h5A);
    rd(3'd6, "R9 rx count", 8'hA5);
    rd(3'd7, "R9 unused address", 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_gate();
    t_clear();
    t_collision();
    t_accumulate();
    t_latest();
    t_counts();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule